// File: doc/BRIEF.md
# Programmable Triggered Pulse Generator

This block is a clocked one-shot. A rising edge on the trigger input starts a single output pulse. The pulse lasts a fixed inherent number of clock cycles plus one cycle for each unit of the programmed width word. A true output and a complementary output are both driven. A separate abort input cuts a running pulse short and holds the output low while it stays asserted. Triggers are locked out while a pulse runs and for a recovery window after it ends, whether the pulse ended normally or through abort.

The width word reaches the counter in one of two ways, chosen by an enable input. With the enable high, the word passes straight through and is sampled when the pulse starts. With the enable low, the block uses the value it captured on the last cycle the enable was high, so the width bus is free to carry other traffic.

The trigger and abort inputs are asynchronous. Each passes through a two-flop synchronizer, and this gives a fixed start and stop latency of three clock edges.

The controller has four states:
- `PG_IDLE` waits for an edge. It moves to `PG_ACTIVE` on a synchronized rising edge.
- `PG_ACTIVE` counts the width. When the count is exhausted it moves to `PG_RECOVER`, or to `PG_IDLE` if the recovery length is zero.
- `PG_RECOVER` counts the lockout window, then returns to `PG_IDLE`.
- `PG_HOLD` is entered from any state while abort is asserted. When abort is released it moves to `PG_RECOVER`, or to `PG_IDLE` if the recovery length is zero.

Top module: `pulse_gen`

## Requirements
- R1: After `rst_n` is released with no trigger, `pulse_out` is 0 and `pulse_out_n` is 1.
- R2: `trig_in` is driven high between clock edges. `pulse_out` is first high after the third following rising clock edge. A trigger held high at a constant level starts no further pulse.
- R3: A pulse that is not aborted stays high for exactly `INH_CYCLES + W` clock cycles, where W is the effective width word taken as an unsigned integer.
- R4: `pulse_out_n` is always the inverse of `pulse_out`.
- R5: A trigger rising edge that arrives while a pulse is high neither changes that pulse's width nor starts a later pulse.
- R6: After a pulse falls, `REC_CYCLES` further clock edges pass before a trigger edge is accepted. `trig_in` raised in the half-cycle right after the fall is ignored when `REC_CYCLES >= 3`. `trig_in` raised one cycle later starts a pulse.
- R7: `abort_in` is raised between edges. `pulse_out` is low after the third following edge and stays low while abort is held. Trigger edges that arrive during this time start nothing.
- R8: `abort_in` is dropped, and `trig_in` is raised k clock cycles later. A pulse starts only when k is greater than `REC_CYCLES`.
- R9: With `addr_en` = 1, W is the value of `addr_in` when the pulse starts. With `addr_en` = 0, W is the `addr_in` value present on the last clock edge at which `addr_en` was 1, and later changes of `addr_in` are ignored.
- R10: W = 0 gives exactly `INH_CYCLES` cycles. W = all ones gives `INH_CYCLES + 2^ADDR_W - 1` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| trig_in | input | 1 | Asynchronous trigger; its rising edge starts a pulse |
| abort_in | input | 1 | Asynchronous abort; ends a pulse early and holds the output low |
| addr_en | input | 1 | 1: width word passes through; 0: captured word is used |
| addr_in | input | ADDR_W | Programmed width word W |
| pulse_out | output | 1 | Registered pulse output |
| pulse_out_n | output | 1 | Complement of pulse_out |

## Verification
Two functions can fall in the same cycle:
- The end of lockout, when the controller returns to idle.
- The arrival of a synchronized trigger edge.

The bench provokes this pairing by raising the trigger at measured offsets after a pulse falls, and again after abort is released. In each case one offset lands its edge on the last lockout cycle and the next offset lands it on the first idle cycle. The outcome is judged at the output pins: the earlier offset must produce no pulse, and the later one must produce a pulse of the full programmed width.

A second collision occurs when abort lands on a pulse that is still counting. The pulse must drop on the third edge after abort rises, regardless of the count remaining.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

    typedef enum logic [1:0] {
        PG_IDLE    = 2'd0,
        PG_ACTIVE  = 2'd1,
        PG_RECOVER = 2'd2,
        PG_HOLD    = 2'd3
    } pg_state_t;

endpackage

// File: rtl/pgen_sync.sv
module pgen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        genvar g;
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pgen_edge.sv
module pgen_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_d;

    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign rise = level & ~level_d;
endmodule

// File: rtl/pgen_addr_hold.sv
module pgen_addr_hold #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pass_en,
    input  logic [ADDR_W-1:0] word_in,
    output logic [ADDR_W-1:0] word_eff
);
    logic [ADDR_W-1:0] held;

    always_ff @(posedge clk) begin
        if (!rst_n)       held <= '0;
        else if (pass_en) held <= word_in;
    end

    assign word_eff = pass_en ? word_in : held;
endmodule

// File: rtl/pgen_counter.sv
module pgen_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (load)             cnt <= load_val;
        else if (dec && cnt != '0) cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/pulse_gen.sv
module pulse_gen #(
    parameter int ADDR_W     = 8,
    parameter int INH_CYCLES = 4,
    parameter int REC_CYCLES = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_in,
    input  logic              abort_in,
    input  logic              addr_en,
    input  logic [ADDR_W-1:0] addr_in,
    output logic              pulse_out,
    output logic              pulse_out_n
);
    import pgen_pkg::*;

    localparam int MAX_WIDTH = INH_CYCLES + (1 << ADDR_W) - 1;
    localparam int MAX_LOAD  = (MAX_WIDTH > REC_CYCLES) ? MAX_WIDTH : REC_CYCLES;
    localparam int CNT_W     = $clog2(MAX_LOAD + 1);
    localparam int INH_LOAD  = (INH_CYCLES > 0) ? INH_CYCLES - 1 : 0;
    localparam int REC_LOAD  = (REC_CYCLES > 0) ? REC_CYCLES - 1 : 0;
    localparam bit HAS_REC   = (REC_CYCLES > 0);

    logic              trig_s;
    logic              abort_s;
    logic              trig_rise;
    logic [ADDR_W-1:0] addr_eff;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_dec;
    logic              cnt_zero;
    pg_state_t         state;
    pg_state_t         nxt;
    logic              pulse_r;

    pgen_sync #(.STAGES(SYNC_STAGES)) u_trig_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (trig_in),
        .sync_out (trig_s)
    );

    pgen_sync #(.STAGES(SYNC_STAGES)) u_abort_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (abort_in),
        .sync_out (abort_s)
    );

    pgen_edge u_trig_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (trig_s),
        .rise  (trig_rise)
    );

    pgen_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pass_en  (addr_en),
        .word_in  (addr_in),
        .word_eff (addr_eff)
    );

    pgen_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .dec      (cnt_dec),
        .zero     (cnt_zero)
    );

    // Next-state and counter control
    always_comb begin
        nxt      = state;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        if (abort_s) begin
            nxt = PG_HOLD;
        end else begin
            unique case (state)
                PG_IDLE: begin
                    if (trig_rise) begin
                        nxt      = PG_ACTIVE;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(INH_LOAD) + CNT_W'(addr_eff);
                    end
                end
                PG_ACTIVE: begin
                    if (cnt_zero) begin
                        if (HAS_REC) begin
                            nxt      = PG_RECOVER;
                            cnt_load = 1'b1;
                            cnt_val  = CNT_W'(REC_LOAD);
                        end else begin
                            nxt = PG_IDLE;
                        end
                    end else begin
                        cnt_dec = 1'b1;
                    end
                end
                PG_RECOVER: begin
                    if (cnt_zero) nxt = PG_IDLE;
                    else          cnt_dec = 1'b1;
                end
                PG_HOLD: begin
                    if (HAS_REC) begin
                        nxt      = PG_RECOVER;
                        cnt_load = 1'b1;
                        cnt_val  = CNT_W'(REC_LOAD);
                    end else begin
                        nxt = PG_IDLE;
                    end
                end
                default: nxt = PG_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PG_IDLE;
        else        state <= nxt;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_r <= 1'b0;
        else        pulse_r <= (nxt == PG_ACTIVE);
    end

    assign pulse_out   = pulse_r;
    assign pulse_out_n = ~pulse_r;
endmodule

// File: rtl/pulse_gen_chk.sv
module pulse_gen_chk #(
    parameter int REC_CYCLES = 3
) (
    input logic clk,
    input logic rst_n,
    input logic pulse_out,
    input logic pulse_out_n,
    input logic trig_rise,
    input logic abort_s,
    input logic cnt_zero
);
    p_compl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out_n == !pulse_out);

    p_start_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> $past(trig_rise));

    p_width_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && !abort_s && !cnt_zero) |=> pulse_out);

    p_abort_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort_s |=> !pulse_out);

    generate
        if (REC_CYCLES > 0) begin : g_rec
            p_recover_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(pulse_out) |=> !pulse_out);
        end
    endgenerate
endmodule

bind pulse_gen pulse_gen_chk #(.REC_CYCLES(REC_CYCLES)) u_pulse_gen_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pulse_out   (pulse_out),
    .pulse_out_n (pulse_out_n),
    .trig_rise   (trig_rise),
    .abort_s     (abort_s),
    .cnt_zero    (cnt_zero)
);

// File: tb/test_pulse_gen.sv
module test_pulse_gen;
    localparam int AW  = 8;
    localparam int INH = 4;
    localparam int REC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          trig_in = 1'b0;
    logic          abort_in = 1'b0;
    logic          addr_en = 1'b1;
    logic [AW-1:0] addr_in = '0;
    logic          pulse_out;
    logic          pulse_out_n;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pulse_gen #(.ADDR_W(AW), .INH_CYCLES(INH), .REC_CYCLES(REC)) i_pulse_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_in     (trig_in),
        .abort_in    (abort_in),
        .addr_en     (addr_en),
        .addr_in     (addr_in),
        .pulse_out   (pulse_out),
        .pulse_out_n (pulse_out_n)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Count high cycles from the current (first high) negedge
    task automatic count_high(output int w, output bit comp_ok);
        w = 0;
        comp_ok = 1'b1;
        while (pulse_out && w < 5000) begin
            w++;
            if (pulse_out_n == pulse_out) comp_ok = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic settle();
        trig_in = 1'b0;
        repeat (REC + 6) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(pulse_out == 1'b0, "R1 reset pulse_out", int'(pulse_out), 0);
        chk(pulse_out_n == 1'b1, "R1/R4 reset pulse_out_n", int'(pulse_out_n), 1);
    endtask

    task automatic t_measure(input logic [AW-1:0] a, input logic en, input int expw, input string rq);
        int w;
        bit comp_ok;
        bit lvl_bad;
        addr_in = a;
        addr_en = en;
        @(negedge clk);
        trig_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(pulse_out == 1'b0, "R2 early start", int'(pulse_out), 0);
        @(negedge clk);
        chk(pulse_out == 1'b1, "R2 start latency", int'(pulse_out), 1);
        count_high(w, comp_ok);
        chk(w == expw, rq, w, expw);
        chk(comp_ok, "R4 complement during pulse", int'(comp_ok), 1);
        lvl_bad = 1'b0;
        repeat (REC + 8) begin
            if (pulse_out) lvl_bad = 1'b1;
            @(negedge clk);
        end
        chk(!lvl_bad, "R2 held level restarts", int'(lvl_bad), 0);
        settle();
    endtask

    task automatic t_latched();
        addr_en = 1'b1;
        addr_in = 8'd7;
        @(negedge clk);
        addr_en = 1'b0;
        addr_in = 8'd100;
        @(negedge clk);
        t_measure(8'd120, 1'b0, INH + 7, "R9 latched width");
    endtask

    task automatic t_retrig_active();
        int w;
        bit comp_ok;
        bit extra;
        addr_in = 8'd30;
        addr_en = 1'b1;
        @(negedge clk);
        trig_in = 1'b1;
        repeat (3) @(negedge clk);
        trig_in = 1'b0;
        w = 1;
        repeat (4) @(negedge clk);
        trig_in = 1'b1;
        w = w + 4;
        begin
            int rest;
            count_high(rest, comp_ok);
            w = w - 1 + rest;
        end
        chk(w == INH + 30, "R5 width with mid-pulse edge", w, INH + 30);
        extra = 1'b0;
        repeat (REC + 10) begin
            if (pulse_out) extra = 1'b1;
            @(negedge clk);
        end
        chk(!extra, "R5 no pulse from ignored edge", int'(extra), 0);
        settle();
    endtask

    task automatic t_recovery(input int k, input bit expect_start);
        int w;
        bit comp_ok;
        bit seen;
        addr_in = 8'd2;
        addr_en = 1'b1;
        @(negedge clk);
        trig_in = 1'b1;
        repeat (3) @(negedge clk);
        trig_in = 1'b0;
        count_high(w, comp_ok);
        repeat (k) @(negedge clk);
        trig_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(pulse_out == expect_start, "R6 recovery boundary", int'(pulse_out), int'(expect_start));
        if (expect_start) begin
            count_high(w, comp_ok);
            chk(w == INH + 2, "R6 width after recovery", w, INH + 2);
        end else begin
            seen = 1'b0;
            repeat (8) begin
                if (pulse_out) seen = 1'b1;
                @(negedge clk);
            end
            chk(!seen, "R6 lockout edge stays ignored", int'(seen), 0);
        end
        settle();
    endtask

    task automatic t_abort();
        bit seen;
        addr_in = 8'd40;
        addr_en = 1'b1;
        @(negedge clk);
        trig_in = 1'b1;
        repeat (3) @(negedge clk);
        repeat (4) @(negedge clk);
        abort_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(pulse_out == 1'b1, "R7 abort latency high", int'(pulse_out), 1);
        @(negedge clk);
        chk(pulse_out == 1'b0, "R7 abort ends pulse", int'(pulse_out), 0);
        trig_in = 1'b0;
        repeat (3) @(negedge clk);
        trig_in = 1'b1;
        seen = 1'b0;
        repeat (8) begin
            if (pulse_out) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R7 trigger ignored while abort held", int'(seen), 0);
        abort_in = 1'b0;
        seen = 1'b0;
        repeat (REC + 10) begin
            if (pulse_out) seen = 1'b1;
            @(negedge clk);
        end
        chk(!seen, "R7 consumed edge after release", int'(seen), 0);
        settle();
    endtask

    task automatic t_abort_release(input int k, input bit expect_start);
        int w;
        bit comp_ok;
        addr_in = 8'd3;
        addr_en = 1'b1;
        @(negedge clk);
        abort_in = 1'b1;
        repeat (5) @(negedge clk);
        abort_in = 1'b0;
        repeat (k) @(negedge clk);
        trig_in = 1'b1;
        repeat (3) @(negedge clk);
        chk(pulse_out == expect_start, "R8 release recovery boundary", int'(pulse_out), int'(expect_start));
        if (expect_start) begin
            count_high(w, comp_ok);
            chk(w == INH + 3, "R8 width after release", w, INH + 3);
        end
        settle();
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_measure(8'd0, 1'b1, INH, "R10 zero word width");
        t_measure(8'd5, 1'b1, INH + 5, "R3/R9 transparent width");
        t_measure(8'd255, 1'b1, INH + 255, "R10 max word width");
        t_latched();
        t_retrig_active();
        t_recovery(REC - 3, 1'b0);
        t_recovery(REC - 2, 1'b1);
        t_abort();
        t_abort_release(REC, 1'b0);
        t_abort_release(REC + 1, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule